// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Lockable Action

This block guards a small microcontroller against runaway software. A down-counter, `CNT_W` bits wide (15 by default), is decremented once per prescaler tick. The prescaler divides the CPU clock by one of two ratios (`DIV_LO` or `DIV_HI`, 16 and 128 by default). One timeout therefore lasts the chosen ratio times 2^`CNT_W` clock cycles. After a system reset the block sits idle. Software arms it by writing the start register. From then on it must keep writing the refresh register before the count runs out.

When the count runs out, the block takes one of two actions. In interrupt mode it raises a one-cycle interrupt request, reloads and keeps counting. In reset mode it raises a reset request for `RST_HOLD` cycles and then falls back to the idle state. Software can select reset mode but can never leave it; only a system reset does that. A low-power input freezes both the prescaler and the counter, and counting resumes from the held values when the input drops.

Software reaches the block through a single-cycle write port. Address 0 is start, address 1 is refresh and address 2 is configuration. For start and refresh the data value does not matter. The interrupt and reset requests go to the interrupt controller and to the reset sequencer.

Top module: `wdog_guard`

## Requirements
- R1: After system reset (`rst_n` low), both `irq_o` and `rst_req_o` are 0, and the block stays idle with no event for as long as nothing starts it.
- R2: A refresh write (`wr_addr` = 1) while the block is idle is ignored: it neither starts the timer nor causes any later event.
- R3: A start write (`wr_addr` = 0, any data) loads the counter with all ones and clears the prescaler. The first timeout event is registered exactly ratio × 2^`CNT_W` cycles after the clock edge that took the write.
- R4: Configuration bit 0 (`wr_addr` = 2, `wr_data[0]`) selects the ratio: 0 divides by `DIV_LO`, 1 divides by `DIV_HI`.
- R5: A refresh write while running reloads all ones and clears the prescaler, so the next event follows a full period after that write's edge.
- R6: In interrupt mode (configuration bit 1 = 0), a timeout drives `irq_o` high for exactly one cycle. The counter reloads and runs on, so the next pulse follows one full period later.
- R7: In reset mode (configuration bit 1 = 1), a timeout drives `rst_req_o` high for exactly `RST_HOLD` consecutive cycles. The block then returns to idle and produces no event until it is started again. Start writes while the request is high are ignored.
- R8: Configuration bit 1 is set-only. Writing 0 to it after it is 1 leaves it at 1, and a reset request does not clear it either; only `rst_n` clears it.
- R9: While `lp_hold` is high, the prescaler and the counter keep their values, so the timeout is delayed by exactly the number of cycles `lp_hold` was high.
- R10: `irq_o` and `rst_req_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 2 | Register select: 0 start, 1 refresh, 2 configuration |
| wr_data | input | 8 | Write data; bit 0 ratio select, bit 1 reset-mode lock |
| lp_hold | input | 1 | Stop/wait low-power indication; freezes counting |
| irq_o | output | 1 | One-cycle timeout interrupt request |
| rst_req_o | output | 1 | Timeout reset request, held `RST_HOLD` cycles |

## Verification
The bench predicts the exact cycle of every event from the write edges and the hold lengths, so a design with an off-by-one in the prescaler or the count would deliver the request a few cycles early or late.

Several mistakes would be visible as extra or missing events:
- Honouring a refresh while idle would start a timer that should never fire.
- Letting a 0 write clear the mode bit would turn the reset request into an interrupt.
- Leaving the timer running after a reset request would produce a second event during the quiet window.

A low-power hold that failed to freeze the prescaler would shift the event by the hold length. A second system reset checks that the lock is cleared only by `rst_n`.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    WD_IDLE   = 2'd0,
    WD_RUN    = 2'd1,
    WD_RSTREQ = 2'd2
  } wd_state_e;

  localparam logic [1:0] ADDR_START = 2'd0;
  localparam logic [1:0] ADDR_KICK  = 2'd1;
  localparam logic [1:0] ADDR_CFG   = 2'd2;

  localparam int CFG_RATIO_BIT  = 0;
  localparam int CFG_ACTION_BIT = 1;

endpackage

// File: rtl/wdog_regif.sv
module wdog_regif
  import wdog_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              start_o,
  output logic              kick_o,
  output logic              ratio_hi_o,
  output logic              act_rst_o
);

  logic ratio_hi_q, ratio_hi_d;
  logic act_rst_q, act_rst_d;
  logic cfg_we;

  logic unused_data_bits;
  assign unused_data_bits = ^wr_data_i[DATA_W-1:2];

  // Address decode: start and refresh act in the cycle of the write
  assign start_o = wr_en_i && (wr_addr_i == ADDR_START);
  assign kick_o  = wr_en_i && (wr_addr_i == ADDR_KICK);
  assign cfg_we  = wr_en_i && (wr_addr_i == ADDR_CFG);

  always_comb begin
    ratio_hi_d = ratio_hi_q;
    act_rst_d  = act_rst_q;
    if (cfg_we) begin
      ratio_hi_d = wr_data_i[CFG_RATIO_BIT];
      // set-only: a 0 write leaves the mode untouched
      act_rst_d  = act_rst_q | wr_data_i[CFG_ACTION_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_hi_q <= 1'b0;
      act_rst_q  <= 1'b0;
    end else begin
      ratio_hi_q <= ratio_hi_d;
      act_rst_q  <= act_rst_d;
    end
  end

  assign ratio_hi_o = ratio_hi_q;
  assign act_rst_o  = act_rst_q;

  assert_mode_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    act_rst_q |=> act_rst_q);

  assert_ratio_written_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == ADDR_CFG) |=> (ratio_hi_q == $past(wr_data_i[CFG_RATIO_BIT])));

endmodule

// File: rtl/wdog_prediv.sv
module wdog_prediv #(
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic hold_i,
  input  logic clr_i,
  input  logic hi_sel_i,
  output logic tick_o
);

  localparam int PW = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;
  localparam logic [PW-1:0] LO_TOP = PW'(DIV_LO - 1);
  localparam logic [PW-1:0] HI_TOP = PW'(DIV_HI - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [PW-1:0] top;
  logic          step;

  assign top    = hi_sel_i ? HI_TOP : LO_TOP;
  assign step   = en_i && !hold_i;
  // compare with >= so a ratio change mid-period cannot overrun
  assign tick_o = step && (pre_q >= top);

  always_comb begin
    pre_d = pre_q;
    if (clr_i) begin
      pre_d = '0;
    end else if (step) begin
      if (tick_o) pre_d = '0;
      else        pre_d = pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assert_prescale_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !clr_i) |=> $stable(pre_q));

endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
  parameter int CNT_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic dec_i,
  output logic zero_o
);

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = FULL;
    else if (dec_i) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= FULL;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  assert_reload_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == FULL));

endmodule

// File: rtl/wdog_action.sv
module wdog_action
  import wdog_pkg::*;
#(
  parameter int RST_HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic kick_i,
  input  logic tick_i,
  input  logic zero_i,
  input  logic act_rst_i,
  output logic run_o,
  output logic load_o,
  output logic irq_o,
  output logic rst_req_o
);

  localparam int HW = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(RST_HOLD - 1);

  wd_state_e     state_q, state_d;
  logic [HW-1:0] hcnt_q, hcnt_d;
  logic          irq_q, irq_d;
  logic          start_ok, kick_ok, expire;

  assign run_o    = (state_q == WD_RUN);
  assign start_ok = start_i && (state_q != WD_RSTREQ);
  assign kick_ok  = kick_i && run_o;
  // a start or refresh in the same cycle wins over the timeout
  assign expire   = run_o && tick_i && zero_i && !start_i && !kick_i;
  assign load_o   = start_ok || kick_ok || (expire && !act_rst_i);

  always_comb begin
    state_d = state_q;
    hcnt_d  = hcnt_q;
    irq_d   = 1'b0;
    unique case (state_q)
      WD_IDLE: begin
        if (start_i) state_d = WD_RUN;
      end
      WD_RUN: begin
        if (expire) begin
          if (act_rst_i) begin
            state_d = WD_RSTREQ;
            hcnt_d  = '0;
          end else begin
            irq_d = 1'b1;
          end
        end
      end
      WD_RSTREQ: begin
        if (hcnt_q == HOLD_LAST) state_d = WD_IDLE;
        else                     hcnt_d  = hcnt_q + HW'(1);
      end
      default: state_d = WD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_IDLE;
      hcnt_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hcnt_q  <= hcnt_d;
      irq_q   <= irq_d;
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = (state_q == WD_RSTREQ);

  assert_idle_kick_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_IDLE && kick_i && !start_i) |=> (state_q == WD_IDLE));

  assert_start_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_IDLE && start_i) |=> (state_q == WD_RUN));

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  assert_rstreq_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req_o) |-> (state_q == WD_IDLE));

  assert_no_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_q && rst_req_o));

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 15,
  parameter int DIV_LO   = 16,
  parameter int DIV_HI   = 128,
  parameter int RST_HOLD = 4,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lp_hold,
  output logic              irq_o,
  output logic              rst_req_o
);

  logic start_p, kick_p, ratio_hi, act_rst;
  logic run, load, tick, zero;

  wdog_regif #(.DATA_W(DATA_W)) u_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .start_o    (start_p),
    .kick_o     (kick_p),
    .ratio_hi_o (ratio_hi),
    .act_rst_o  (act_rst)
  );

  wdog_prediv #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_prediv (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (run),
    .hold_i   (lp_hold),
    .clr_i    (load),
    .hi_sel_i (ratio_hi),
    .tick_o   (tick)
  );

  wdog_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .dec_i  (tick),
    .zero_o (zero)
  );

  wdog_action #(.RST_HOLD(RST_HOLD)) u_action (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_p),
    .kick_i    (kick_p),
    .tick_i    (tick),
    .zero_i    (zero),
    .act_rst_i (act_rst),
    .run_o     (run),
    .load_o    (load),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

endmodule

// File: tb/sim_wdog_guard.sv
`timescale 1ns/1ps
module sim_wdog_guard;

  localparam int CW = 6, DL = 4, DH = 16, RH = 4;
  localparam longint P_LO = longint'(DL) * (longint'(1) << CW);
  localparam longint P_HI = longint'(DH) * (longint'(1) << CW);
  localparam int K_IRQ = 1, K_RST = 2;

  typedef struct { int kind; longint at; string req; } ev_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       lp_hold;
  logic       irq_o, rst_req_o;

  longint cyc = 0;
  int checks = 0, errors = 0, ev_cnt = 0;
  ev_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_guard #(.CNT_W(CW), .DIV_LO(DL), .DIV_HI(DH), .RST_HOLD(RH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lp_hold(lp_hold), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output longint e);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    e = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_ev(int kind, longint at, string req);
    ev_t item;
    item.kind = kind; item.at = at; item.req = req;
    q.push_back(item);
  endtask

  task automatic wait_until(longint t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic hold_for(int n);
    @(negedge clk);
    lp_hold = 1'b1;
    repeat (n) @(negedge clk);
    lp_hold = 1'b0;
  endtask

  // monitor: pops the scoreboard as events appear
  task automatic take(int kind);
    ev_t item;
    ev_cnt++;
    if (q.size() == 0) begin
      chk(1'b0, "R1", "unexpected event kind", kind, 0);
    end else begin
      item = q.pop_front();
      chk(kind == item.kind, item.req, "event kind", kind, item.kind);
      chk(cyc == item.at, item.req, "event cycle", cyc, item.at);
    end
  endtask

  bit prev_rst = 1'b0;
  int rlen = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_rst = 1'b0;
      rlen = 0;
    end else begin
      if (irq_o) take(K_IRQ);
      if (rst_req_o && !prev_rst) take(K_RST);
      if (rst_req_o) rlen++;
      if (!rst_req_o && prev_rst) begin
        chk(rlen == RH, "R7", "reset request length", rlen, RH);
        rlen = 0;
      end
      if (irq_o && rst_req_o) chk(1'b0, "R10", "both requests high", 1, 0);
      prev_rst = rst_req_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung at cycle %0d expected end before %0d", cyc, 200000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint e, k, c, s;
    int base;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; lp_hold = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_o == 1'b0, "R1", "irq after reset", irq_o, 0);
    chk(rst_req_o == 1'b0, "R1", "reset request after reset", rst_req_o, 0);

    // R2: refresh before start does nothing
    base = ev_cnt;
    wr(2'd1, 8'h00, e);
    repeat (600) @(negedge clk);
    chk(ev_cnt == base, "R2", "events while idle", ev_cnt - base, 0);

    // R3 / R6: start in interrupt mode, low ratio, two periods
    wr(2'd2, 8'h00, c);
    wr(2'd0, 8'h5A, e);
    expect_ev(K_IRQ, e + P_LO, "R3");
    expect_ev(K_IRQ, e + 2 * P_LO, "R6");
    wait_until(e + 2 * P_LO + 2);

    // R5: refresh while running restarts the period
    repeat (100) @(negedge clk);
    wr(2'd1, 8'h00, k);
    expect_ev(K_IRQ, k + P_LO, "R5");
    wait_until(k + P_LO + 2);

    // R4: high ratio
    wr(2'd2, 8'h01, c);
    wr(2'd1, 8'h00, k);
    expect_ev(K_IRQ, k + P_HI, "R4");
    wait_until(k + P_HI + 2);

    // R9: low-power hold delays by its length
    wr(2'd1, 8'h00, k);
    expect_ev(K_IRQ, k + P_HI + 37, "R9");
    repeat (200) @(negedge clk);
    hold_for(37);
    wait_until(k + P_HI + 37 + 2);

    // R7 / R8: lock reset mode, try to clear it, then time out
    wr(2'd2, 8'h03, c);
    wr(2'd2, 8'h01, c);
    wr(2'd1, 8'h00, k);
    expect_ev(K_RST, k + P_HI, "R8");
    wait_until(k + P_HI + RH + 4);

    // R7: back to idle afterwards, refresh still ignored
    base = ev_cnt;
    wr(2'd1, 8'h00, k);
    repeat (1500) @(negedge clk);
    chk(ev_cnt == base, "R7", "events after reset request", ev_cnt - base, 0);

    // R8: mode survives its own reset request
    wr(2'd0, 8'h00, s);
    expect_ev(K_RST, s + P_HI, "R8");
    wait_until(s + P_HI + RH + 4);

    // R8: only system reset clears the mode
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wr(2'd0, 8'h00, s);
    expect_ev(K_IRQ, s + P_LO, "R8");
    wait_until(s + P_LO + 2);

    chk(q.size() == 0, "R6", "missing expected events", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule